// File: doc/BRIEF.md
# Delayed Register Update Queue

This block holds register updates that must not take effect at once. Each accepted request names a destination register, a tick delay, an update kind and a value. The request then waits in one of a fixed number of slots arranged as a ring. Every `tick` pulse counts every live slot down by one. A slot whose count reaches zero writes its update into a small internal register file on that same tick. The file is read through a combinational read port. One update kind sets or clears a single bit. The other overwrites the whole destination, either 32 bits wide or 64 bits wide.

Each slot counts down on its own, so a younger request with a short delay can take effect before an older request with a long delay. A slot is given back to the ring only when it is the oldest occupied slot. A slot that has fired but is not yet the oldest stays marked as retired and keeps its place, so it still counts against capacity. A request that arrives while all slots are occupied is dropped, and the drop is reported by a one-cycle `overflow` pulse. A separate flag reports an internal inconsistency: the two ring pointers differ while the occupancy is zero.

An occupancy controller tracks how full the ring is with three states:
- `ST_EMPTY` goes to `ST_BUSY` on an accepted request.
- `ST_BUSY` goes to `ST_EMPTY` when the next occupancy is zero, and to `ST_FULL` when the next occupancy equals the slot count.
- `ST_FULL` goes to `ST_EMPTY` or `ST_BUSY` when a tick frees one or more slots.

Requests are refused only in `ST_FULL`.

Top module: `delay_update_queue`

## Requirements
- R1: After reset, every register in the file reads zero, and `overflow` and `cons_err` are low.
- R2: A request accepted at a clock edge with delay D (1..15) takes effect at the edge of the D-th later cycle in which `tick` is high. A tick in the same cycle as the request does not count. A delay of 0 is treated as 1.
- R3: A request made while all 8 slots are occupied is dropped and leaves the register file unchanged. `overflow` is high for exactly the one cycle after that edge.
- R4: With `enq_bit_mode`=1, the update sets bit `enq_bit_pos` of the destination when `enq_value` is nonzero and clears it otherwise. With `enq_wide`=0, the position used is `enq_bit_pos` modulo 32.
- R5: With `enq_bit_mode`=0 and `enq_wide`=1, the update replaces all 64 bits of the destination.
- R6: With `enq_bit_mode`=0 and `enq_wide`=0, the update replaces bits 31:0 of the destination and keeps bits 63:32.
- R7: Slots count down independently. A younger request with a shorter delay takes effect first, and the older request still takes effect on its own schedule.
- R8: A slot is freed only once every older slot has been freed. A fired slot behind an unexpired older slot still occupies capacity.
- R9: When several slots fire on the same tick, they apply in the order they were accepted, so the newest write to a register wins.
- R10: In cycles with `tick` low, no slot counts down and the occupancy does not change, except for an accepted request.
- R11: `cons_err` is high when the ring pointers differ while occupancy is zero. It stays low in all legal operation.
- R12: `rd_data` shows register `rd_idx` of the file combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Request an update this cycle |
| enq_dst | input | 2 | Destination register index |
| enq_delay | input | 4 | Ticks until the update takes effect (0 acts as 1) |
| enq_bit_mode | input | 1 | 1: single-bit update, 0: full write |
| enq_bit_pos | input | 6 | Bit position for single-bit updates |
| enq_value | input | 64 | Write data, or set/clear selector in bit mode |
| enq_wide | input | 1 | 1: 64-bit destination, 0: 32-bit destination |
| tick | input | 1 | Count-down strobe |
| rd_idx | input | 2 | Read port register index |
| rd_data | output | 64 | Read port data |
| overflow | output | 1 | Pulse: the previous cycle's request was dropped |
| cons_err | output | 1 | Ring pointer consistency error |

## Verification
Register-file results appear on `rd_data` right after the clock edge of the tick that makes a slot fire. `overflow` rises right after the edge at which a request meets a full ring. The driver applies one cycle of stimulus on the falling edge, together with the read index. It pushes the value that a reference ring model predicts for just after the next rising edge. The monitor samples one nanosecond after that rising edge, while the read index of that cycle is still held. So every comparison falls in the first cycle where the result is due, and never on the edge itself.

// File: rtl/dq_pkg.sv
package dq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/dq_merge.sv
module dq_merge #(
    parameter  int DATA_W = 64,
    localparam int POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic              bit_mode,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic [DATA_W-1:0] value,
    input  logic              wide,
    output logic [DATA_W-1:0] new_word
);
    localparam int HALF = DATA_W / 2;

    logic [POS_W-1:0] eff_pos;

    always_comb begin
        // Narrow destinations fold the position into the low half.
        eff_pos  = wide ? bit_pos : {1'b0, bit_pos[POS_W-2:0]};
        new_word = old_word;
        if (bit_mode) begin
            new_word[eff_pos] = |value;
        end else if (wide) begin
            new_word = value;
        end else begin
            new_word[HALF-1:0] = value[HALF-1:0];
        end
    end
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
    import dq_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int CNT_W = $clog2(SLOTS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [CNT_W-1:0] n_free,
    output logic             accept,
    output logic             overflow,
    output logic [CNT_W-1:0] occ
);
    occ_state_e       state, state_nx;
    logic [CNT_W-1:0] occ_nx;

    always_comb begin
        accept   = enq_valid && (state != ST_FULL);
        occ_nx   = occ - n_free + CNT_W'(accept);
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_BUSY;
            ST_BUSY: begin
                if (occ_nx == '0)                     state_nx = ST_EMPTY;
                else if (occ_nx == CNT_W'(SLOTS))     state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (n_free != '0) state_nx = (occ_nx == '0) ? ST_EMPTY : ST_BUSY;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            occ   <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= enq_valid && (state == ST_FULL);
    end
endmodule

// File: rtl/delay_update_queue.sv
module delay_update_queue #(
    parameter  int SLOTS  = 8,
    parameter  int DLY_W  = 4,
    parameter  int NREGS  = 4,
    parameter  int DATA_W = 64,
    localparam int PTR_W  = $clog2(SLOTS),
    localparam int CNT_W  = PTR_W + 1,
    localparam int REG_W  = $clog2(NREGS),
    localparam int POS_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [REG_W-1:0]  enq_dst,
    input  logic [DLY_W-1:0]  enq_delay,
    input  logic              enq_bit_mode,
    input  logic [POS_W-1:0]  enq_bit_pos,
    input  logic [DATA_W-1:0] enq_value,
    input  logic              enq_wide,
    input  logic              tick,
    input  logic [REG_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              overflow,
    output logic              cons_err
);
    // Slot storage
    logic [REG_W-1:0]  s_dst  [SLOTS];
    logic [DLY_W-1:0]  s_dly  [SLOTS];
    logic [POS_W-1:0]  s_pos  [SLOTS];
    logic [DATA_W-1:0] s_val  [SLOTS];
    logic [SLOTS-1:0]  s_bit, s_wide, s_live;

    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  occ, n_free;
    logic              accept;
    logic [SLOTS-1:0]  occ_mask, fire_slot;

    logic [NREGS-1:0][DATA_W-1:0]       rf;
    logic [SLOTS:0][NREGS-1:0][DATA_W-1:0] chain;

    dq_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_valid(enq_valid),
        .n_free   (n_free),
        .accept   (accept),
        .overflow (overflow),
        .occ      (occ)
    );

    // Which slots are in the occupied window, and which expire now
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            logic [PTR_W-1:0] offs;
            offs         = PTR_W'(i) - head;
            occ_mask[i]  = {1'b0, offs} < occ;
            fire_slot[i] = tick && occ_mask[i] && s_live[i] && (s_dly[i] == DLY_W'(1));
        end
    end

    // Free the run of retired slots starting at the oldest
    always_comb begin
        logic             stop;
        logic [PTR_W-1:0] idxf;
        n_free = '0;
        stop   = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            idxf = head + PTR_W'(k);
            if (!stop && tick && occ_mask[idxf] && !(s_live[idxf] && !fire_slot[idxf]))
                n_free = n_free + 1'b1;
            else
                stop = 1'b1;
        end
    end

    // Apply expiring updates oldest first, so later writes win
    assign chain[0] = rf;
    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_stage
            logic [PTR_W-1:0]             idx;
            logic [DATA_W-1:0]            old_w, new_w;
            logic [NREGS-1:0][DATA_W-1:0] nxt;

            assign idx   = head + PTR_W'(k);
            assign old_w = chain[k][s_dst[idx]];

            dq_merge #(.DATA_W(DATA_W)) u_merge (
                .old_word(old_w),
                .bit_mode(s_bit[idx]),
                .bit_pos (s_pos[idx]),
                .value   (s_val[idx]),
                .wide    (s_wide[idx]),
                .new_word(new_w)
            );

            always_comb begin
                nxt = chain[k];
                if (fire_slot[idx]) nxt[s_dst[idx]] = new_w;
            end
            assign chain[k+1] = nxt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            tail   <= '0;
            s_live <= '0;
            s_bit  <= '0;
            s_wide <= '0;
            rf     <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                s_dst[i] <= '0;
                s_dly[i] <= '0;
                s_pos[i] <= '0;
                s_val[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (tick && occ_mask[i] && s_live[i]) begin
                    s_dly[i] <= s_dly[i] - 1'b1;
                    if (fire_slot[i]) s_live[i] <= 1'b0;
                end
            end
            if (accept) begin
                s_dst[tail]  <= enq_dst;
                s_dly[tail]  <= (enq_delay == '0) ? DLY_W'(1) : enq_delay;
                s_pos[tail]  <= enq_bit_pos;
                s_val[tail]  <= enq_value;
                s_bit[tail]  <= enq_bit_mode;
                s_wide[tail] <= enq_wide;
                s_live[tail] <= 1'b1;
            end
            head <= head + PTR_W'(n_free);
            tail <= tail + PTR_W'(accept);
            rf   <= chain[SLOTS];
        end
    end

    assign rd_data  = rf[rd_idx];
    assign cons_err = (head != tail) && (occ == '0);
endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             tick,
    input logic             overflow,
    input logic             cons_err,
    input logic [CNT_W-1:0] occ
);
    // R3: a drop pulse needs a request against a full ring one cycle earlier
    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(enq_valid) && ($past(occ) == CNT_W'(SLOTS))));

    // R8: occupancy never exceeds the ring size
    p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(SLOTS));

    // R11: pointer consistency holds in legal use
    p_no_cons_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_err);

    // R10: no tick and no request leaves occupancy unchanged
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !enq_valid) |=> $stable(occ));

    // R2: occupancy grows only through a request
    p_grow_by_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid |=> (occ <= $past(occ)));
endmodule

bind delay_update_queue dq_checker #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_valid(enq_valid),
    .tick     (tick),
    .overflow (overflow),
    .cons_err (cons_err),
    .occ      (occ)
);

// File: tb/delay_update_queue_bench.sv
`timescale 1ns/1ps
module delay_update_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [1:0]  enq_dst = '0;
    logic [3:0]  enq_delay = '0;
    logic        enq_bit_mode = 1'b0;
    logic [5:0]  enq_bit_pos = '0;
    logic [63:0] enq_value = '0;
    logic        enq_wide = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        overflow, cons_err;

    always #2.5 clk = ~clk;  // 200 MHz

    delay_update_queue u_delay_update_queue (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_dst(enq_dst),
        .enq_delay(enq_delay), .enq_bit_mode(enq_bit_mode), .enq_bit_pos(enq_bit_pos),
        .enq_value(enq_value), .enq_wide(enq_wide), .tick(tick), .rd_idx(rd_idx),
        .rd_data(rd_data), .overflow(overflow), .cons_err(cons_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model: pending requests in acceptance order
    typedef struct {
        int          dst;
        int          rem;
        bit          bm;
        int          pos;
        logic [63:0] val;
        bit          wide;
        bit          done;
    } pend_t;
    pend_t       mq[$];
    logic [63:0] mrf [4];

    typedef struct {
        string       tag;
        logic [63:0] val;
        logic        ovf;
    } exp_t;
    exp_t sb[$];

    function automatic void model_apply(pend_t p);
        int b;
        if (p.bm) begin
            b = p.wide ? p.pos : (p.pos % 32);
            mrf[p.dst][b] = (p.val != 0);
        end else if (p.wide) begin
            mrf[p.dst] = p.val;
        end else begin
            mrf[p.dst][31:0] = p.val[31:0];
        end
    endfunction

    task automatic step(input bit en, input int dst, input int dly, input bit bm,
                        input int pos, input logic [63:0] val, input bit wide,
                        input bit tk, input int rdi, input string tag);
        exp_t  e;
        pend_t p;
        bit    ovf;
        @(negedge clk);
        ovf = en && (mq.size() == 8);
        if (tk) begin
            foreach (mq[i]) begin
                if (!mq[i].done) begin
                    mq[i].rem = mq[i].rem - 1;
                    if (mq[i].rem == 0) begin
                        model_apply(mq[i]);
                        mq[i].done = 1;
                    end
                end
            end
            while (mq.size() > 0 && mq[0].done) void'(mq.pop_front());
        end
        if (en && !ovf) begin
            p.dst = dst; p.rem = (dly == 0) ? 1 : dly; p.bm = bm; p.pos = pos;
            p.val = val; p.wide = wide; p.done = 0;
            mq.push_back(p);
        end
        e.tag = tag; e.val = mrf[rdi]; e.ovf = ovf;
        sb.push_back(e);
        enq_valid = en; enq_dst = 2'(dst); enq_delay = 4'(dly); enq_bit_mode = bm;
        enq_bit_pos = 6'(pos); enq_value = val; enq_wide = wide; tick = tk;
        rd_idx = 2'(rdi);
    endtask

    task automatic idle(input bit tk, input int rdi, input string tag);
        step(0, 0, 0, 0, 0, 64'h0, 0, tk, rdi, tag);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_vec++;
                if (rd_data !== e.val || overflow !== e.ovf || cons_err !== 1'b0) begin
                    n_bad++;
                    $display("FAIL %s: rd_data=%h overflow=%b cons_err=%b expected rd_data=%h overflow=%b cons_err=0",
                             e.tag, rd_data, overflow, cons_err, e.val, e.ovf);
                end
            end
        end
    end

    initial begin
        #60000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) mrf[r] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R12: reset contents through the combinational read port
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            rd_idx = 2'(r);
            #1;
            n_vec++;
            if (rd_data !== 64'h0 || overflow !== 1'b0 || cons_err !== 1'b0) begin
                n_bad++;
                $display("FAIL R1/R12 reg%0d: rd_data=%h ovf=%b err=%b expected 0 0 0",
                         r, rd_data, overflow, cons_err);
            end
        end

        // R2, R4: 64-bit bit set after two ticks
        step(1, 1, 2, 1, 40, 64'h1, 1, 0, 1, "R2 enqueue");
        idle(1, 1, "R2 first tick");
        idle(1, 1, "R4 bit set wide");
        // R2 delay zero acts as one; R5 full 64-bit write
        step(1, 2, 0, 0, 0, 64'hA5A5_0000_FFFF_0001, 1, 0, 2, "R2 zero delay");
        idle(1, 2, "R5 full write wide");
        // R10: no countdown without tick
        step(1, 3, 1, 0, 0, 64'h3333, 1, 0, 3, "R10 enqueue");
        idle(0, 3, "R10 hold");
        idle(0, 3, "R10 hold");
        idle(0, 3, "R10 hold");
        idle(1, 3, "R10 tick applies");
        // R6: narrow full write keeps upper half
        step(1, 2, 1, 0, 0, 64'hFFFF_FFFF_1234_5678, 0, 0, 2, "R6 enqueue");
        idle(1, 2, "R6 low half only");
        // R4: narrow bit set folds position 40 to 8; wide clear of bit 40
        step(1, 1, 1, 1, 40, 64'h1, 0, 0, 1, "R4 enqueue");
        idle(1, 1, "R4 narrow set");
        step(1, 1, 1, 1, 40, 64'h0, 1, 0, 1, "R4 enqueue");
        idle(1, 1, "R4 wide clear");
        // R7: younger short delay first
        step(1, 0, 5, 0, 0, 64'h1111, 1, 0, 0, "R7 older");
        step(1, 3, 1, 0, 0, 64'h2222, 1, 0, 3, "R7 younger");
        idle(1, 3, "R7 younger applied");
        for (int i = 0; i < 4; i++) idle(1, 0, "R7 older countdown");
        // R8 / R3: retired slots behind a long delay keep capacity
        step(1, 0, 15, 0, 0, 64'hAAAA, 1, 0, 0, "R8 long head");
        for (int i = 0; i < 7; i++)
            step(1, 2, 1, 0, 0, 64'h100 + 64'(i), 1, 0, 2, "R8 fill");
        idle(1, 2, "R9 newest of same tick wins");
        step(1, 3, 1, 0, 0, 64'hDEAD, 1, 0, 3, "R3 R8 overflow while retired slots held");
        idle(1, 3, "R3 dropped request has no effect");
        for (int i = 0; i < 13; i++) idle(1, 0, "R8 long head countdown");
        step(1, 3, 1, 0, 0, 64'hBEEF, 1, 0, 3, "R3 accepted after drain");
        idle(1, 3, "R3 accepted request applies");
        // R9: two same-delay writes to one register
        step(1, 1, 1, 0, 0, 64'h9999_0000, 1, 0, 1, "R9 first");
        step(1, 1, 1, 0, 0, 64'h7777, 1, 0, 1, "R9 second");
        idle(1, 1, "R9 later write wins");
        // R12: read every register
        for (int r = 0; r < 4; r++) idle(0, r, "R12 read port");
        repeat (3) @(posedge clk);
        #1;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule